// File: doc/BRIEF.md
# Preloadable 8-bit Timer with Event and Pulse-Width Modes

This block is an up-counter with a small host register interface. A single select line chooses between a data address and a control address. At the data address, a host write fills a hidden preload register, and a host read returns the live count. At the control address, the host sets the operating mode, the run enable and the active edge.

In event mode the counter steps once per active edge of an external input. In timer mode it steps on a tick of the system clock divided by four. In pulse-width mode it measures how long the external input stays at its active level, in system clock cycles. When the pulse ends, the hardware drops the run bit. The counter always counts up. On a step past its all-ones value it reloads from the preload register and raises a sticky interrupt request, which stays set until the host sends a clear strobe.

Top module: `evt_timer`

## Requirements
- R1: After reset, the count reads 0x00, the control register reads 0x00 and irq_o is low.
- R2: A write with sel_i=0 changes only the preload register. A read with sel_i=0 returns the live count, which that write leaves unchanged.
- R3: Control fields: bits 7:6 are the mode (00 off, 01 event, 10 timer, 11 pulse width), bit 4 is run and bit 3 is the edge select (0 rising, 1 falling). Bits 5 and 2:0 always read 0.
- R4: Event mode with run=1: the counter steps once per active edge of ext_i, after a two-flop synchronizer. Transitions of the opposite direction do not step it.
- R5: Timer mode with run=1: the counter steps once every 4 system clocks, counted from the write that enables it.
- R6: With run=0 or mode 00, the count holds whatever the activity on ext_i.
- R7: A step from 0xFF loads the count from the preload register and sets irq_o.
- R8: irq_o stays high until irq_clr_i is pulsed, and the pulse drives it low.
- R9: Pulse-width mode with run=1: after an active edge, the count grows by the number of clocks that the input holds its active level (rising edge: high pulse; falling edge: low pulse).
- R10: In pulse-width mode, the end of the measured pulse clears the run bit. This clear wins over a host control write in the same cycle, while that write's other fields still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Register select: 0 data, 1 control |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| ext_i | input | 1 | External event / pulse input |
| irq_clr_i | input | 1 | Clears the interrupt request |
| irq_o | output | 1 | Sticky overflow interrupt request |

## Verification
The counting paths are driven by a vector table of edge trains, idle holds and single pulses. An edge train ends on a rising edge, so it holds one more rising edge than falling edges, and the two polarities give counts that differ by exactly one. Idle holds with run cleared or mode off must leave the count at zero. Single pulses of different lengths and both polarities show that the measured width tracks the pulse length cycle for cycle. Directed tests cover preload-only writes, a wrap from 0xFF with the sticky flag and its clear, and a host write that lands in the very cycle the hardware clears run.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'b00,
    MODE_EVT = 2'b01,
    MODE_TMR = 2'b10,
    MODE_PW  = 2'b11
  } mode_e;

  localparam int unsigned CTRL_W     = 8;
  localparam int unsigned MODE_LSB   = 6;
  localparam int unsigned RUN_BIT    = 4;
  localparam int unsigned EDGE_BIT   = 3;
endpackage

// File: rtl/evt_edge_sync.sv
module evt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], in_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/evt_prescale.sv
module evt_prescale #(
  parameter int unsigned DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          div_q <= '0;
    else if (!en_i)       div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                  div_q <= div_q + 1'b1;
  end

  assign tick_o = en_i & (div_q == LAST);
endmodule

// File: rtl/evt_count_core.sv
module evt_count_core #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic [W-1:0] preload_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  assign ovf_o = inc_i & (&cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (ovf_o) cnt_q <= preload_i;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned PRESCALE    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             sel_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic             ext_i,
  input  logic             irq_clr_i,
  output logic             irq_o
);
  logic [CNT_W-1:0] preload_q;
  logic [CNT_W-1:0] cnt_q;
  mode_e            mode_q;
  logic             run_q;
  logic             edge_q;
  logic             meas_q;
  logic             irq_q;

  logic rise, fall, act_edge, ret_edge;
  logic tick, tmr_en, pw_en, hw_clr, inc, ovf;
  logic ctrl_wr, data_wr;
  logic [CTRL_W-1:0] ctrl_rd;

  assign ctrl_wr = wr_en_i &  sel_i;
  assign data_wr = wr_en_i & ~sel_i;

  evt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .in_i  (ext_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  assign act_edge = edge_q ? fall : rise;
  assign ret_edge = edge_q ? rise : fall;

  assign tmr_en = run_q & (mode_q == MODE_TMR);
  assign pw_en  = run_q & (mode_q == MODE_PW);

  evt_prescale #(.DIV(PRESCALE)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tmr_en),
    .tick_o(tick)
  );

  // pulse measurement: edge cycle counts, then every held cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                meas_q <= 1'b0;
    else if (!pw_en)            meas_q <= 1'b0;
    else if (meas_q & ret_edge) meas_q <= 1'b0;
    else if (act_edge)          meas_q <= 1'b1;
  end

  assign hw_clr = pw_en & meas_q & ret_edge;

  always_comb begin
    unique case (mode_q)
      MODE_EVT: inc = run_q & act_edge;
      MODE_TMR: inc = tick;
      MODE_PW:  inc = pw_en & (meas_q ? ~ret_edge : act_edge);
      default:  inc = 1'b0;
    endcase
  end

  evt_count_core #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inc_i    (inc),
    .preload_i(preload_q),
    .cnt_o    (cnt_q),
    .ovf_o    (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      preload_q <= '0;
      mode_q    <= MODE_OFF;
      run_q     <= 1'b0;
      edge_q    <= 1'b0;
    end else begin
      if (data_wr) preload_q <= wdata_i;
      if (ctrl_wr) begin
        mode_q <= mode_e'(wdata_i[MODE_LSB +: 2]);
        edge_q <= wdata_i[EDGE_BIT];
      end
      // hardware clear wins over host write
      if (hw_clr)       run_q <= 1'b0;
      else if (ctrl_wr) run_q <= wdata_i[RUN_BIT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (ovf)       irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end

  always_comb begin
    ctrl_rd                 = '0;
    ctrl_rd[MODE_LSB +: 2]  = mode_q;
    ctrl_rd[RUN_BIT]        = run_q;
    ctrl_rd[EDGE_BIT]       = edge_q;
  end

  assign rdata_o = sel_i ? CNT_W'(ctrl_rd) : cnt_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_i,
  input logic             wr_en_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] rdata_o,
  input logic             irq_o,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] preload,
  input logic             run,
  input logic [1:0]       mode
);
  a_r3_unused_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_i |-> (rdata_o[5] == 1'b0 && rdata_o[2:0] == 3'b000));

  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run || mode == 2'b00) |=> $stable(cnt));

  a_r5_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt != $past(cnt)) |-> (cnt == $past(cnt) + 1'b1 || cnt == $past(preload)));

  a_r7_wrap_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(irq_o) && !$past(wr_en_i && !sel_i)) |-> (cnt == preload));

  a_r8_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_clr_i) |=> irq_o);
endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_i    (sel_i),
  .wr_en_i  (wr_en_i),
  .irq_clr_i(irq_clr_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .cnt      (cnt_q),
  .preload  (preload_q),
  .run      (run_q),
  .mode     (mode_q)
);

// File: tb/tb_evt_timer.sv
module tb_evt_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       ext_i = 1'b0;
  logic       irq_clr_i = 1'b0;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  evt_timer dut (.*);

  // {ctrl, kind, n, expected}; kind 0 edge train, 1 hold, 2 single pulse
  localparam int NV = 10;
  localparam logic [25:0] VEC [NV] = '{
    {8'h50, 2'd0, 8'd5,  8'd5 },
    {8'h58, 2'd0, 8'd5,  8'd4 },
    {8'h50, 2'd0, 8'd1,  8'd1 },
    {8'h90, 2'd1, 8'd40, 8'd10},
    {8'h90, 2'd1, 8'd7,  8'd1 },
    {8'h10, 2'd0, 8'd5,  8'd0 },
    {8'h40, 2'd0, 8'd5,  8'd0 },
    {8'h00, 2'd1, 8'd20, 8'd0 },
    {8'hD0, 2'd2, 8'd7,  8'd7 },
    {8'hD8, 2'd2, 8'd12, 8'd12}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_reset(input logic base);
    rst_ni = 1'b0;
    ext_i = base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; sel_i = s; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] d);
    @(negedge clk_i);
    sel_i = s;
    #1 d = rdata_o;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] v;
    // R1 reset state
    do_reset(1'b0);
    rd(1'b0, v); check("R1 count", v, 8'h00);
    rd(1'b1, v); check("R1 ctrl", v, 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);

    // R3 unused bits read zero
    wr(1'b1, 8'hFF);
    rd(1'b1, v); check("R3 ctrl mask", v, 8'hD8);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [7:0] c, n, e;
      logic [1:0] k;
      logic base;
      {c, k, n, e} = VEC[i];
      base = (k == 2'd2) && c[3];
      do_reset(base);
      wr(1'b1, c);
      repeat (2) @(negedge clk_i);
      case (k)
        2'd0: begin
          for (int j = 0; j < n; j++) begin
            ext_i = 1'b1; repeat (3) @(negedge clk_i);
            if (j != n - 1) begin ext_i = 1'b0; repeat (3) @(negedge clk_i); end
          end
          repeat (6) @(negedge clk_i);
        end
        2'd1: begin
          repeat (int'(n) - 2) @(posedge clk_i);
        end
        default: begin
          ext_i = ~base;
          repeat (n) @(negedge clk_i);
          ext_i = base;
          repeat (6) @(negedge clk_i);
        end
      endcase
      rd(1'b0, v);
      // R4 event edges, R5 timer rate, R6 idle hold, R9 pulse width
      check($sformatf("R4/R5/R6/R9 vector %0d", i), v, e);
    end

    // R2 preload write leaves count alone; R7 wrap; R8 sticky flag
    do_reset(1'b0);
    wr(1'b0, 8'hFC);
    rd(1'b0, v); check("R2 count after preload write", v, 8'h00);
    wr(1'b1, 8'h90);
    repeat (1025) @(posedge clk_i);
    rd(1'b0, v); check("R7 reload value", v, 8'hFC);
    check("R7 irq set", {7'd0, irq_o}, 8'h01);
    repeat (10) @(posedge clk_i);
    check("R8 irq held", {7'd0, irq_o}, 8'h01);
    @(negedge clk_i); irq_clr_i = 1'b1;
    @(negedge clk_i); irq_clr_i = 1'b0;
    check("R8 irq cleared", {7'd0, irq_o}, 8'h00);
    repeat (5) @(posedge clk_i);
    rd(1'b0, v); check("R7 second wrap", v, 8'hFC);
    check("R7 irq again", {7'd0, irq_o}, 8'h01);

    // R10 pulse end clears run
    do_reset(1'b0);
    wr(1'b1, 8'hD0);
    repeat (2) @(negedge clk_i);
    ext_i = 1'b1; repeat (5) @(negedge clk_i);
    ext_i = 1'b0; repeat (6) @(negedge clk_i);
    rd(1'b1, v); check("R10 run cleared", v, 8'hC0);
    rd(1'b0, v); check("R9 width 5", v, 8'h05);

    // R10 hardware clear beats simultaneous host write
    do_reset(1'b0);
    wr(1'b1, 8'hD0);
    repeat (2) @(negedge clk_i);
    ext_i = 1'b1; repeat (4) @(negedge clk_i);
    ext_i = 1'b0;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b1; sel_i = 1'b1; wdata_i = 8'hD8;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    rd(1'b1, v); check("R10 clear precedence", v, 8'hC8);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule